// File: doc/BRIEF.md
# Tunable Second-Order Allpass Fractional Delayer

This block delays a fixed-point sample stream by a run-time adjustable, non-integer number of samples. It is a second-order recursive allpass filter. The total delay is 2 + d samples, and the signed control d lies between -0.5 and +0.5. The design target is the maximally flat allpass approximation. Each of the two filter coefficients is a cubic polynomial in d. The block evaluates both polynomials in Horner form with the d that arrives with each sample, so retuning needs no reload of coefficients.

The eight polynomial constants are elaboration-time parameters, each written as a short list of signed power-of-two terms. The block expands them into shift-and-add sums.

Samples and d are signed Q1.15 values. The recursion keeps two state words and a few guard bits above the sample width, and it saturates both the state and the output. The block accepts one sample per clock. Each input sample produces exactly one output sample.

Top module: `tunable_allpass_fd`

## Requirements
- R1: Each cycle in which `in_valid` is sampled high produces exactly one `out_valid` pulse, two clock edges later. `out_valid` is never high otherwise. While `out_valid` is low, `out_sample` holds the last output value.
- R2: With d = 0, the output is the input stream delayed by exactly two accepted samples, bit for bit. After reset, the first two outputs are 0.
- R3: A coefficient is h0 + d(h1 + d(h2 + d·h3)) in Q2.16, where d is the raw Q1.15 integer. Each product with d is rounded as (p + 2^14) >> 15, with an arithmetic shift, before the next constant is added.
- R3 (continued): Each constant is the sum of its enabled terms. A term is 7 bits: bit 6 enables it, bit 5 negates it, and bits 4:0 hold k for a weight of 2^-k, so one term counts ±2^(16-k).
- R3 (default constants): for the first coefficient the constants are 0, -43520, 14592 and -4864 (orders 0 to 3). For the second coefficient they are 0, 5440, 2288 and -1760.
- R4: For each accepted sample x, with first coefficient c1, second coefficient c2 and state words s1, s2, the block computes w = sat18(((x<<16) - c1·s1 - c2·s2 + 2^15) >> 16).
- R4 (continued): It then computes y = sat16((c2·w + c1·s1 + (s2<<16) + 2^15) >> 16). After that, s2 takes the value of s1 and s1 takes the value of w. `out_sample` is y.
- R5: Before the coefficients are evaluated, d is clamped to the range -16384..16384.
- R6: d is taken only in a cycle with `in_valid` high, and that d applies to that sample. Values of d in idle cycles change neither the coefficients nor any output.
- R7: The state words saturate to the signed 18-bit range and the output saturates to -32768..32767, including under full-scale alternating and step input at both ends of the d range.
- R8: A constant input held for 80 samples produces an output within ±2 LSB of that input, for d inside the allowed range.
- R9: While `rst` is high at a clock edge, both state words, `out_sample` and `out_valid` are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Input sample, signed Q1.15 |
| frac_d | input | 16 | Fractional delay offset d, signed Q1.15 |
| out_valid | output | 1 | Output strobe, two cycles after the input strobe |
| out_sample | output | 16 | Output sample, signed Q1.15 |

## Verification
The bound assertions check the timing rules on every cycle:
- the two-cycle valid latency;
- that the output holds between strobes;
- that the coefficients stay frozen across idle cycles;
- that the first cycle after reset is quiet.

The arithmetic can only be shown by the bench scenarios, which compare each output against a behavioural integer model. This covers:
- the pure two-sample delay at d = 0;
- bit-exact recursion at several settings of d;
- clamping of out-of-range d;
- saturation under full-scale input;
- unity gain at DC.

// File: rtl/apd_pkg.sv
package apd_pkg;

    localparam int TERM_W  = 7;
    localparam int EN_BIT  = 6;
    localparam int NEG_BIT = 5;
    localparam int SHIFT_W = 5;

    typedef logic [TERM_W-1:0] csd_term_t;

    localparam csd_term_t CSD_OFF = '0;

    function automatic csd_term_t csd_pos(input int k);
        return {1'b1, 1'b0, SHIFT_W'(k)};
    endfunction

    function automatic csd_term_t csd_neg(input int k);
        return {1'b1, 1'b1, SHIFT_W'(k)};
    endfunction

endpackage

// File: rtl/apd_csd_const.sv
module apd_csd_const
    import apd_pkg::*;
#(
    parameter int CF = 16,
    parameter int CW = 18,
    parameter int NT = 4,
    parameter logic [NT-1:0][TERM_W-1:0] TERMS = '0
) (
    output logic signed [CW-1:0] value
);

    logic signed [CW-1:0] term_val [NT];

    for (genvar t = 0; t < NT; t++) begin : g_term
        localparam csd_term_t TRM = TERMS[t];
        localparam int        SH  = int'(TRM[SHIFT_W-1:0]);
        localparam longint    MAG = TRM[EN_BIT] ? (longint'(1) <<< (CF - SH)) : longint'(0);
        assign term_val[t] = TRM[NEG_BIT] ? CW'(-MAG) : CW'(MAG);
    end

    always_comb begin
        value = '0;
        for (int t = 0; t < NT; t++) begin
            value = value + term_val[t];
        end
    end

endmodule

// File: rtl/apd_coef_horner.sv
module apd_coef_horner
    import apd_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 18,
    parameter int CF = 16,
    parameter int NT = 4,
    parameter logic [3:0][NT-1:0][TERM_W-1:0] POLY = '0
) (
    input  logic signed [DW-1:0] d_in,
    output logic signed [CW-1:0] coef
);

    localparam int ORDERS = 4;
    localparam int DF     = DW - 1;
    localparam int PW     = CW + DW;
    localparam logic signed [DW-1:0] D_MAX = DW'(1) <<< (DF - 1);
    localparam logic signed [DW-1:0] D_MIN = -D_MAX;
    localparam logic signed [PW-1:0] RND   = PW'(1) <<< (DF - 1);

    logic signed [CW-1:0] cst [ORDERS];
    logic signed [DW-1:0] d_cl;
    logic signed [CW-1:0] acc;
    logic signed [PW-1:0] prod;

    for (genvar o = 0; o < ORDERS; o++) begin : g_order
        apd_csd_const #(
            .CF(CF), .CW(CW), .NT(NT), .TERMS(POLY[o])
        ) i_const (
            .value(cst[o])
        );
    end

    always_comb begin
        if (d_in > D_MAX) begin
            d_cl = D_MAX;
        end else if (d_in < D_MIN) begin
            d_cl = D_MIN;
        end else begin
            d_cl = d_in;
        end
        acc  = cst[ORDERS-1];
        prod = '0;
        for (int o = ORDERS - 2; o >= 0; o--) begin
            prod = acc * d_cl;
            acc  = CW'((prod + RND) >>> DF) + cst[o];
        end
        coef = acc;
    end

endmodule

// File: rtl/apd_recursion.sv
module apd_recursion #(
    parameter int DW    = 16,
    parameter int CW    = 18,
    parameter int CF    = 16,
    parameter int GUARD = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_x,
    input  logic signed [CW-1:0] c1,
    input  logic signed [CW-1:0] c2,
    output logic                 res_vld,
    output logic signed [DW-1:0] res_y
);

    localparam int SW = DW + GUARD;
    localparam int PW = CW + SW;
    localparam int AW = PW + 2;
    localparam logic signed [AW-1:0] RND  = AW'(1) <<< (CF - 1);
    localparam logic signed [AW-1:0] SMAX = (AW'(1) <<< (SW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);
    localparam logic signed [AW-1:0] YMAX = (AW'(1) <<< (DW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

    typedef struct packed {
        logic signed [SW-1:0] s1;
        logic signed [SW-1:0] s2;
        logic signed [DW-1:0] y;
        logic                 vld;
    } rec_state_t;

    rec_state_t st_d, st_q;

    logic signed [PW-1:0] m_c1s1, m_c2s2, m_c2w;
    logic signed [AW-1:0] acc_w, acc_y, rnd_w, rnd_y;
    logic signed [SW-1:0] w_new;
    logic signed [DW-1:0] y_new;

    always_comb begin
        m_c1s1 = c1 * st_q.s1;
        m_c2s2 = c2 * st_q.s2;
        acc_w  = (AW'(smp_x) <<< CF) - AW'(m_c1s1) - AW'(m_c2s2);
        rnd_w  = (acc_w + RND) >>> CF;
        if (rnd_w > SMAX) begin
            w_new = SW'(SMAX);
        end else if (rnd_w < SMIN) begin
            w_new = SW'(SMIN);
        end else begin
            w_new = SW'(rnd_w);
        end

        m_c2w = c2 * w_new;
        acc_y = AW'(m_c2w) + AW'(m_c1s1) + (AW'(st_q.s2) <<< CF);
        rnd_y = (acc_y + RND) >>> CF;
        if (rnd_y > YMAX) begin
            y_new = DW'(YMAX);
        end else if (rnd_y < YMIN) begin
            y_new = DW'(YMIN);
        end else begin
            y_new = DW'(rnd_y);
        end

        st_d     = st_q;
        st_d.vld = smp_vld;
        if (smp_vld) begin
            st_d.s1 = w_new;
            st_d.s2 = st_q.s1;
            st_d.y  = y_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld = st_q.vld;
    assign res_y   = st_q.y;

endmodule

// File: rtl/tunable_allpass_fd.sv
module tunable_allpass_fd
    import apd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 18,
    parameter int CF    = 16,
    parameter int GUARD = 2,
    parameter int NT    = 4,
    parameter logic [3:0][NT-1:0][TERM_W-1:0] C1_POLY = {
        CSD_OFF,    csd_neg(8), csd_neg(7), csd_neg(4),
        CSD_OFF,    csd_pos(8), csd_neg(5), csd_pos(2),
        csd_neg(7), csd_neg(5), csd_neg(3), csd_neg(1),
        CSD_OFF,    CSD_OFF,    CSD_OFF,    CSD_OFF
    },
    parameter logic [3:0][NT-1:0][TERM_W-1:0] C2_POLY = {
        CSD_OFF,     csd_pos(11), csd_pos(8), csd_neg(5),
        CSD_OFF,     csd_neg(12), csd_pos(8), csd_pos(5),
        csd_pos(10), csd_pos(8),  csd_pos(6), csd_pos(4),
        CSD_OFF,     CSD_OFF,     CSD_OFF,    CSD_OFF
    }
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic signed [DW-1:0] frac_d,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);

    typedef struct packed {
        logic signed [DW-1:0] x;
        logic signed [CW-1:0] c1;
        logic signed [CW-1:0] c2;
        logic                 vld;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    logic signed [CW-1:0] c1_eval, c2_eval;
    logic signed [CW-1:0] coef1_q, coef2_q;

    apd_coef_horner #(
        .DW(DW), .CW(CW), .CF(CF), .NT(NT), .POLY(C1_POLY)
    ) i_horner_c1 (
        .d_in (frac_d),
        .coef (c1_eval)
    );

    apd_coef_horner #(
        .DW(DW), .CW(CW), .CF(CF), .NT(NT), .POLY(C2_POLY)
    ) i_horner_c2 (
        .d_in (frac_d),
        .coef (c2_eval)
    );

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = in_valid;
        if (in_valid) begin
            cap_d.x  = in_sample;
            cap_d.c1 = c1_eval;
            cap_d.c2 = c2_eval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign coef1_q = cap_q.c1;
    assign coef2_q = cap_q.c2;

    apd_recursion #(
        .DW(DW), .CW(CW), .CF(CF), .GUARD(GUARD)
    ) i_recursion (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (cap_q.vld),
        .smp_x   (cap_q.x),
        .c1      (coef1_q),
        .c2      (coef2_q),
        .res_vld (out_valid),
        .res_y   (out_sample)
    );

endmodule

// File: rtl/apd_checker.sv
module apd_checker #(
    parameter int DW = 16,
    parameter int CW = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_sample,
    input logic signed [CW-1:0] coef1_q,
    input logic signed [CW-1:0] coef2_q
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1

    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((since_rst != 2'd0) && !out_valid) |-> $stable(out_sample)); // R1

    AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((since_rst != 2'd0) && !$past(in_valid)) |-> ($stable(coef1_q) && $stable(coef2_q))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && (out_sample == '0))); // R9

endmodule

bind tunable_allpass_fd apd_checker #(.DW(DW), .CW(CW)) i_apd_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .coef1_q    (coef1_q),
    .coef2_q    (coef2_q)
);

// File: tb/test_tunable_allpass_fd.sv
module test_tunable_allpass_fd;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic signed [15:0] frac_d = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;

    always #4 clk = ~clk;

    tunable_allpass_fd i_tunable_allpass_fd (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .frac_d     (frac_d),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    int     n_checks = 0;
    int     n_errors = 0;
    string  cur_tag  = "R9";
    longint s1 = 0, s2 = 0, last_y = 0;
    logic   ev1 = 0, ev2 = 0;
    longint ey1 = 0, ey2 = 0;

    longint P1 [4] = '{0, -43520, 14592, -4864};
    longint P2 [4] = '{0, 5440, 2288, -1760};

    function automatic longint sat(input longint v, input longint lo, input longint hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic longint poly(input longint p [4], input longint d);
        longint h = p[3];
        for (int k = 2; k >= 0; k--) begin
            h = ((h * d + 16384) >>> 15) + p[k];
        end
        return h;
    endfunction

    function automatic longint model(input longint x, input longint d_raw);
        longint d  = sat(d_raw, -16384, 16384);
        longint c1 = poly(P1, d);
        longint c2 = poly(P2, d);
        longint w  = sat(((x <<< 16) - c1 * s1 - c2 * s2 + 32768) >>> 16, -131072, 131071);
        longint y  = sat((c2 * w + c1 * s1 + (s2 <<< 16) + 32768) >>> 16, -32768, 32767);
        s2 = s1;
        s1 = w;
        return y;
    endfunction

    task automatic check(input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", cur_tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input longint x, input longint d);
        @(negedge clk);
        check(out_valid === ev2, longint'(out_valid), longint'(ev2));
        check(longint'(out_sample) == ey2, longint'(out_sample), ey2);
        ev2 = ev1;
        ey2 = ey1;
        in_valid  = v;
        in_sample = 16'(x);
        frac_d    = 16'(d);
        if (v) begin
            last_y = model(x, d);
        end
        ev1 = v;
        ey1 = last_y;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        cur_tag = "R9";
        check(out_valid === 1'b0, longint'(out_valid), 0);
        check(out_sample == 16'sd0, longint'(out_sample), 0);
        rst = 1'b0;
        s1 = 0; s2 = 0; last_y = 0;
        ev1 = 0; ev2 = 0; ey1 = 0; ey2 = 0;
    endtask

    function automatic longint rnd_smp();
        return longint'($signed(16'($urandom)));
    endfunction

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset();

        cur_tag = "R2";
        for (int i = 0; i < 30; i++) step(1'b1, rnd_smp(), 0);
        step(1'b0, 0, 0); step(1'b0, 0, 0);

        cur_tag = "R1";
        for (int i = 0; i < 40; i++) step((i % 3) != 1, rnd_smp(), 9830);
        step(1'b0, 0, 0); step(1'b0, 0, 0);

        cur_tag = "R4";
        foreach (P1[j]) begin
            longint dv [4] = '{9830, -16384, 16384, -8192};
            for (int i = 0; i < 30; i++) step(1'b1, rnd_smp() >>> 1, dv[j]);
        end

        cur_tag = "R3";
        for (int i = 0; i < 30; i++) step(1'b1, rnd_smp() >>> 2, 5000 - i * 600);

        cur_tag = "R6";
        for (int i = 0; i < 20; i++) begin
            step(1'b0, rnd_smp(), rnd_smp());
            step(1'b0, rnd_smp(), rnd_smp());
            step(1'b1, rnd_smp() >>> 1, -3000);
        end

        cur_tag = "R5";
        for (int i = 0; i < 25; i++) step(1'b1, rnd_smp() >>> 1, 32767);
        for (int i = 0; i < 25; i++) step(1'b1, rnd_smp() >>> 1, -32768);
        for (int i = 0; i < 25; i++) step(1'b1, rnd_smp() >>> 1, 20000);

        cur_tag = "R7";
        for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 32767 : -32768, -16384);
        for (int i = 0; i < 30; i++) step(1'b1, (i < 15) ? -32768 : 32767, 16384);
        for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 32767 : -32768, 16384);

        cur_tag = "R8";
        for (int i = 0; i < 80; i++) step(1'b1, 12000, 9830);
        step(1'b0, 0, 0); step(1'b0, 0, 0);
        check((out_sample >= 16'sd11998) && (out_sample <= 16'sd12002), longint'(out_sample), 12000);
        for (int i = 0; i < 80; i++) step(1'b1, -20000, -13000);
        step(1'b0, 0, 0); step(1'b0, 0, 0);
        check((out_sample >= -16'sd20002) && (out_sample <= -16'sd19998), longint'(out_sample), -20000);

        cur_tag = "R9";
        for (int i = 0; i < 10; i++) step(1'b1, rnd_smp(), 7000);
        do_reset();
        cur_tag = "R2";
        for (int i = 0; i < 10; i++) step(1'b1, rnd_smp(), 0);
        step(1'b0, 0, 0); step(1'b0, 0, 0); step(1'b0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule